// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a data cache placed between a processor load/store port and a slower memory port. It stores 8 KB as 256 lines of 32 bytes, each line found by direct mapping from a 34-bit physical byte address. A load that finds its line present returns a 32-bit word on the cycle after it is accepted. A load that misses fetches the whole line as eight word reads, fills the line, and then answers.

Stores are full 32-bit words and are always written through to memory. Each store goes through a four-entry write buffer, so the processor does not wait for memory write latency. A store whose line is present also updates the cached copy. A store that misses leaves the cache untouched, because this block never allocates a line on a write. A load miss is held back while any buffered store targets the same line, so the refill cannot fetch stale data.

The processor side uses a request/ready handshake. On the memory side the block raises `mem_req` and keeps the command steady until memory answers with a one-cycle `mem_ack`.

Top module: `wt_dcache`

## Requirements
- R1: Synchronous reset marks every line invalid. The first load to any address after reset is a miss and reads eight words from memory.
- R2: Address fields are: word select `cpu_addr[4:2]`, line index `cpu_addr[12:5]`, tag `cpu_addr[33:13]`. Bits [1:0] are ignored. Two addresses with the same index but different tags compete for one line, so loading the second evicts the first.
- R3: A load hit raises `cpu_rvalid` with the stored word in the first cycle after the accepting clock edge. It causes no memory read.
- R4: A load miss issues eight read commands, one per word of the line, with addresses rising by 4 from the line base. It then returns the requested word. After this the line hits.
- R5: A store to a present line updates the cached word, so a following load hit returns the new value.
- R6: Every accepted store produces exactly one memory write with its word address and data. The writes reach memory in the order the stores were accepted.
- R7: A store that misses does not make its line present. A later load to that line misses and returns the stored value.
- R8: The write buffer holds four stores. While memory is slow, four back-to-back stores are accepted without waiting, and a fifth is held off (`cpu_ready` low) until an entry drains.
- R9: A load miss whose line matches a buffered store does not start its refill until that store's memory write has completed. The load returns the stored value.
- R10: A load miss whose line matches no buffered store starts its refill without draining the whole buffer first.
- R11: While a miss is being serviced, `cpu_ready` stays low, and memory commands are held steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 34 | Physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request accepted at the next clock edge when high with cpu_req |
| cpu_rvalid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory command valid, held until mem_ack |
| mem_we | output | 1 | 1 = write command, 0 = read command |
| mem_addr | output | 34 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the current command |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest situation to reach is a load miss that meets a write buffer still holding stores. The outcome differs depending on whether one of those stores targets the missed line or only other lines. The bench reaches this situation by slowing the memory model to ten or more cycles per command, then issuing stores and the load back to back. It then compares the write count recorded at the first refill read against the position of the matching store. Back-to-back stores under the same slow memory also drive the buffer to full and expose the stall.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } cache_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_valid,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/wtc_data_ram.sv
module wtc_data_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic [AW-1:0]       push_addr,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic                full,
  output logic                empty,
  output logic [AW-1:0]       head_addr,
  output logic [DW-1:0]       head_data,
  input  logic [AW-SEL_W-1:0] probe_line,
  output logic                probe_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] occ_q;
  logic [DEPTH-1:0] slot_match;
  logic [PTR_W-1:0] wp_q, rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      if (push) begin
        occ_q[wp_q] <= 1'b1;
        wp_q <= (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      end
      if (pop) begin
        occ_q[rp_q] <= 1'b0;
        rp_q <= (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wp_q] <= push_addr;
      data_q[wp_q] <= push_data;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign slot_match[i] = occ_q[i] && (addr_q[i][AW-1:SEL_W] == probe_line);
  end

  assign probe_hit = |slot_match;
  assign full      = &occ_q;
  assign empty     = ~|occ_q;
  assign head_addr = addr_q[rp_q];
  assign head_data = data_q[rp_q];

  AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R8
  AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 256,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int BYTE_W  = $clog2(WORD_W / 8);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int SEL_W   = OFF_W - BYTE_W;
  localparam int BEATS   = 1 << SEL_W;
  localparam int INDEX_W = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;
  localparam int WA_W    = ADDR_W - BYTE_W;
  localparam int LA_W    = ADDR_W - OFF_W;

  cache_state_e state_q;

  logic [INDEX_W-1:0] req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [SEL_W-1:0]   req_sel;
  logic [TAG_W-1:0]   line_tag;
  logic               line_valid;
  logic               hit, accept, ld_hit, ld_miss, st_push, st_hit;
  logic [LA_W-1:0]    miss_line_q;
  logic [SEL_W-1:0]   miss_sel_q, beat_q;
  logic [WORD_W-1:0]  fill_word_q, ram_q;
  logic               src_fill_q, rvalid_q, wr_active_q;
  logic               wb_full, wb_empty, wb_pop, conflict, drain;
  logic [WA_W-1:0]    wb_head_addr;
  logic [WORD_W-1:0]  wb_head_data;
  logic               fill_beat, fill_last, tag_we;
  logic               ram_we;
  logic [INDEX_W+SEL_W-1:0] ram_waddr;
  logic [WORD_W-1:0]  ram_wdata;
  logic               unused_low_bits;

  assign req_idx = cpu_addr[OFF_W +: INDEX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_sel = cpu_addr[BYTE_W +: SEL_W];
  assign unused_low_bits = ^cpu_addr[BYTE_W-1:0];

  wtc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(req_idx), .rd_tag(line_tag), .rd_valid(line_valid),
    .wr_en(tag_we), .wr_idx(miss_line_q[INDEX_W-1:0]),
    .wr_tag(miss_line_q[LA_W-1 -: TAG_W])
  );

  assign hit       = line_valid && (line_tag == req_tag);
  assign cpu_ready = (state_q == ST_IDLE) && !(cpu_we && wb_full);
  assign accept    = cpu_req && cpu_ready;
  assign ld_hit    = accept && !cpu_we && hit;
  assign ld_miss   = accept && !cpu_we && !hit;
  assign st_push   = accept && cpu_we;
  assign st_hit    = st_push && hit;

  // Refill beats and store hits never share a cycle (stores only in idle).
  assign fill_beat = (state_q == ST_FILL) && mem_ack;
  assign fill_last = fill_beat && (beat_q == SEL_W'(BEATS-1));
  assign tag_we    = fill_last;
  assign ram_we    = st_hit || fill_beat;
  assign ram_waddr = st_hit ? {req_idx, req_sel} : {miss_line_q[INDEX_W-1:0], beat_q};
  assign ram_wdata = st_hit ? cpu_wdata : mem_rdata;

  wtc_data_ram #(.AW(INDEX_W + SEL_W), .DW(WORD_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ld_hit), .raddr({req_idx, req_sel}), .rdata(ram_q)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH), .AW(WA_W), .DW(WORD_W), .SEL_W(SEL_W)) u_wbuf (
    .clk(clk), .rst(rst),
    .push(st_push), .push_addr(cpu_addr[ADDR_W-1:BYTE_W]), .push_data(cpu_wdata),
    .pop(wb_pop), .full(wb_full), .empty(wb_empty),
    .head_addr(wb_head_addr), .head_data(wb_head_data),
    .probe_line(miss_line_q), .probe_hit(conflict)
  );

  // Drain runs whenever no refill owns the port; while a miss waits it only
  // continues for a write already in flight or one that blocks the refill.
  assign drain  = !wb_empty && (state_q != ST_FILL) &&
                  (wr_active_q || (state_q == ST_IDLE) || conflict);
  assign wb_pop = drain && mem_ack;

  assign mem_req   = drain || (state_q == ST_FILL);
  assign mem_we    = drain;
  assign mem_addr  = drain ? {wb_head_addr, {BYTE_W{1'b0}}}
                           : {miss_line_q, beat_q, {BYTE_W{1'b0}}};
  assign mem_wdata = wb_head_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wr_active_q <= 1'b0;
      rvalid_q    <= 1'b0;
      src_fill_q  <= 1'b0;
      beat_q      <= '0;
    end else begin
      wr_active_q <= drain && !mem_ack;
      rvalid_q    <= ld_hit || fill_last;
      src_fill_q  <= (state_q == ST_FILL);
      unique case (state_q)
        ST_IDLE: if (ld_miss) state_q <= ST_WAIT;
        ST_WAIT: if (!conflict && !wr_active_q) begin
          state_q <= ST_FILL;
          beat_q  <= '0;
        end
        ST_FILL: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (fill_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ld_miss) begin
      miss_line_q <= cpu_addr[ADDR_W-1:OFF_W];
      miss_sel_q  <= req_sel;
    end
    if (fill_beat && (beat_q == miss_sel_q)) fill_word_q <= mem_rdata;
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = src_fill_q ? fill_word_q : ram_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R11
  AST_FILL_NO_HAZARD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !conflict);  // R9
  AST_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> (mem_ack && !mem_we));  // R7
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $past(ld_miss) |-> !cpu_ready);  // R11
endmodule

// File: tb/wt_dcache_test.sv
module wt_dcache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [33:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int nchk = 0, nerr = 0;
  int mem_lat = 1, wait_c = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] memw [logic [31:0]];
  logic [31:0] gold [logic [31:0]];
  logic [31:0] wr_log[$], wd_log[$], rd_log[$];
  int          rd_snap[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_dcache uut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] initv(logic [31:0] wa);
    return (wa * 32'h9E3779B1) ^ 32'hC3A50000;
  endfunction

  function automatic logic [31:0] expv(logic [31:0] wa);
    return gold.exists(wa) ? gold[wa] : initv(wa);
  endfunction

  function automatic logic [33:0] mk(logic [20:0] t, logic [7:0] i, logic [2:0] w);
    return {t, i, w, 2'b00};
  endfunction

  // Memory model: decides at the falling edge, ack seen at the next rising edge.
  always @(negedge clk) begin
    logic [31:0] wa;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end else if (mem_req && !rst) begin
      if (wait_c >= mem_lat) begin
        mem_ack = 1'b1;
        wait_c  = 0;
        wa = mem_addr[33:2];
        if (mem_we) begin
          memw[wa] = mem_wdata;
          wr_log.push_back(wa);
          wd_log.push_back(mem_wdata);
          wr_cnt++;
        end else begin
          mem_rdata = memw.exists(wa) ? memw[wa] : initv(wa);
          rd_log.push_back(wa);
          rd_snap.push_back(wr_cnt);
          rd_cnt++;
        end
      end else begin
        wait_c++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic access(input bit we, input logic [33:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output int stall);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    stall = 0; lat = 0; rd = '0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      stall++;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we) gold[a[33:2]] = d;
    else begin
      lat = 1;
      while (!cpu_rvalid) begin
        @(negedge clk);
        lat++;
      end
      rd = cpu_rdata;
    end
  endtask

  task automatic settle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk); #1;
      if (!mem_req && !mem_ack) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [33:0] a;
    int lat, stall, r0, w0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(cpu_ready && !cpu_rvalid && !mem_req, "R1", "idle state after reset",
        {cpu_ready, cpu_rvalid, mem_req}, 3'b100);

    // R1 / R4: first load after reset misses and fills in address order
    a = mk(21'h01234, 8'h05, 3'd2);
    r0 = rd_cnt;
    access(1'b0, a, 0, rd, lat, stall);
    chk(rd_cnt - r0 == 8, "R1", "reads on first load", rd_cnt - r0, 8);
    for (int k = 0; k < 8; k++)
      chk(rd_log[r0 + k] == {a[33:5], 3'(k)}, "R4", "refill beat address",
          rd_log[r0 + k], {a[33:5], 3'(k)});
    chk(rd == expv(a[33:2]), "R4", "miss data", rd, expv(a[33:2]));

    // R3: hit in same line, one-cycle latency, no memory read
    r0 = rd_cnt;
    access(1'b0, mk(21'h01234, 8'h05, 3'd7), 0, rd, lat, stall);
    chk(lat == 1 && rd_cnt == r0, "R3", "hit latency/no read", lat, 1);
    chk(rd == expv({21'h01234, 8'h05, 3'd7}), "R3", "hit data", rd,
        expv({21'h01234, 8'h05, 3'd7}));

    // Sweep: several lines, every word; first word misses, rest hit
    for (int li = 0; li < 8; li++) begin
      for (int w = 0; w < 8; w++) begin
        a = mk(21'h00100 + 21'(li * 37), 8'(16 * li + 1), 3'(w));
        r0 = rd_cnt;
        access(1'b0, a, 0, rd, lat, stall);
        chk(rd == expv(a[33:2]), "R4", "sweep data", rd, expv(a[33:2]));
        if (w == 0) chk(rd_cnt - r0 == 8, "R4", "sweep miss reads", rd_cnt - r0, 8);
        else chk(lat == 1 && rd_cnt == r0, "R3", "sweep hit latency", lat, 1);
      end
    end

    // R2: same index, different tag evicts
    access(1'b0, mk(21'h0AAAA, 8'h09, 3'd1), 0, rd, lat, stall);
    access(1'b0, mk(21'h15555, 8'h09, 3'd1), 0, rd, lat, stall);
    chk(rd == expv({21'h15555, 8'h09, 3'd1}), "R2", "second tag data", rd,
        expv({21'h15555, 8'h09, 3'd1}));
    r0 = rd_cnt;
    access(1'b0, mk(21'h0AAAA, 8'h09, 3'd1), 0, rd, lat, stall);
    chk(rd_cnt - r0 == 8, "R2", "evicted line misses again", rd_cnt - r0, 8);
    r0 = rd_cnt;
    access(1'b0, mk(21'h0AAAA, 8'h09, 3'd1) | 34'h3, 0, rd, lat, stall);
    chk(rd_cnt == r0 && rd == expv({21'h0AAAA, 8'h09, 3'd1}), "R2",
        "low bits ignored", rd, expv({21'h0AAAA, 8'h09, 3'd1}));

    // R5 / R6: store hit writes cache and memory
    settle();
    a = mk(21'h01234, 8'h05, 3'd4);
    w0 = wr_cnt;
    access(1'b1, a, 32'hDEAD_0001, rd, lat, stall);
    r0 = rd_cnt;
    access(1'b0, a, 0, rd, lat, stall);
    chk(lat == 1 && rd_cnt == r0, "R5", "load after store hit is hit", lat, 1);
    chk(rd == 32'hDEAD_0001, "R5", "store hit data", rd, 32'hDEAD_0001);
    settle();
    chk(wr_cnt - w0 == 1, "R6", "one write per store", wr_cnt - w0, 1);
    chk(wr_log[w0] == a[33:2] && wd_log[w0] == 32'hDEAD_0001, "R6", "write addr/data",
        {wr_log[w0], wd_log[w0]}, {a[33:2], 32'hDEAD_0001});

    // R7: store miss does not allocate
    a = mk(21'h03333, 8'h40, 3'd6);
    access(1'b1, a, 32'hBEEF_0007, rd, lat, stall);
    settle();
    r0 = rd_cnt;
    access(1'b0, a, 0, rd, lat, stall);
    chk(rd_cnt - r0 == 8, "R7", "store-miss line still misses", rd_cnt - r0, 8);
    chk(rd == 32'hBEEF_0007, "R7", "data after store miss", rd, 32'hBEEF_0007);

    // R8 / R6: buffer full stall and write order
    mem_lat = 12;
    settle();
    w0 = wr_cnt;
    for (int s = 0; s < 5; s++) begin
      access(1'b1, mk(21'h04000 + 21'(s), 8'h50 + 8'(s), 3'(s)), 32'h5000_0000 + s,
             rd, lat, stall);
      if (s < 4) chk(stall == 0, "R8", "store accepted without wait", stall, 0);
      else chk(stall > 0, "R8", "fifth store stalls", stall, 1);
    end
    settle();
    for (int s = 0; s < 5; s++)
      chk(wr_log[w0 + s] == {21'h04000 + 21'(s), 8'h50 + 8'(s), 3'(s)} &&
          wd_log[w0 + s] == 32'h5000_0000 + s, "R6", "write order",
          wr_log[w0 + s], {21'h04000 + 21'(s), 8'h50 + 8'(s), 3'(s)});

    // R9: load miss behind a store to the same line
    mem_lat = 10;
    settle();
    a = mk(21'h05A5A, 8'h60, 3'd3);
    w0 = wr_cnt;
    r0 = rd_cnt;
    access(1'b1, a, 32'hCAFE_0009, rd, lat, stall);
    access(1'b0, a, 0, rd, lat, stall);
    chk(rd_snap[r0] >= w0 + 1, "R9", "refill waits for matching write", rd_snap[r0], w0 + 1);
    chk(rd == 32'hCAFE_0009, "R9", "fresh data after hazard", rd, 32'hCAFE_0009);

    // R10: non-matching buffered stores do not hold the refill
    settle();
    w0 = wr_cnt;
    r0 = rd_cnt;
    for (int s = 0; s < 3; s++)
      access(1'b1, mk(21'h06000, 8'h70, 3'(s)), 32'h7000_0000 + s, rd, lat, stall);
    a = mk(21'h06001, 8'h71, 3'd5);
    access(1'b0, a, 0, rd, lat, stall);
    chk(rd_snap[r0] - w0 < 3, "R10", "refill starts before buffer empties",
        rd_snap[r0] - w0, 2);
    chk(rd == expv(a[33:2]), "R10", "data for unrelated miss", rd, expv(a[33:2]));
    settle();
    chk(wr_cnt - w0 == 3, "R6", "all buffered stores written", wr_cnt - w0, 3);

    // R11: ready low during a miss
    mem_lat = 4;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(21'h07777, 8'h80, 3'd0);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk(!cpu_ready, "R11", "ready low while miss pending", cpu_ready, 0);
    while (!cpu_rvalid) @(negedge clk);
    chk(cpu_rdata == expv({21'h07777, 8'h80, 3'd0}), "R11", "data after busy miss",
        cpu_rdata, expv({21'h07777, 8'h80, 3'd0}));

    finish_run();
  end
endmodule